// File: doc/BRIEF.md
# Mode-Selectable Asynchronous Serial Transmitter

This block drives one asynchronous serial output line from two CPU-visible registers: a write-only character register and a mode register. The three low mode bits select what the line does. One bit forces the line to mark (constant 1). One bit sends framed characters built from the character register. One bit sends framed characters whose data bits are all zero, which serves as a test pattern. With every mode bit clear the transmitter is off and the line idles at 1.

Each frame has one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). Every bit lasts `CLK_DIV` system clocks. In the two framing modes, a write of the character register starts a frame if the transmitter is idle. The character is first captured in a launch stage. The frame state machine then moves through its states:

- `ST_IDLE`: entered on reset, after the stop bit, or on an abort. It goes to `ST_START` on a launch.
- `ST_START`: goes to `ST_DATA` at the end of the bit.
- `ST_DATA`: stays in `ST_DATA` until the last data bit, then goes to `ST_STOP`.
- `ST_STOP`: goes to `ST_IDLE` at the end of the bit.

Turning on the mark override aborts any frame from any state back to `ST_IDLE`. A read-only busy flag in the mode readback shows that a frame is pending or in progress.

Top module: `modal_serial_tx`

## Requirements
- R1: After reset the mode readback is 0x0000, the busy flag is 0 and `tx_line` is 1.
- R2: With mode bits [2:0] all 0, a character-register write starts no frame: busy stays 0 and `tx_line` stays 1.
- R3: With mode bit 1 set and bit 2 clear, a character-register write while idle starts a frame. The start bit (0) begins at the clock edge after the write edge. It is followed by data bits 0..7 of the written value, LSB first, and then a stop bit (1). Each bit lasts `CLK_DIV` clocks.
- R4: With only mode bit 0 set among bits [2:0], a character-register write sends a frame whose eight data bits are all 0, whatever value was written.
- R5: With mode bits 1 and 0 both set, the frame carries the written value, so bit 1 wins over bit 0.
- R6: While mode bit 2 is 1, `tx_line` is 1. Setting bit 2 abandons any frame in progress, and busy is 0 from the next cycle. Character writes start no frame while bit 2 is set. After bit 2 clears, framing works again.
- R7: The mode readback has mode bits [2:0] as last written in bits [2:0] and the busy flag in bit 3. Bits 15:4 read 0. Writes to bits 15:3 have no effect. Busy reads 1 from the first cycle after a launching write until the stop bit ends.
- R8: A character-register write during a frame neither changes the frame in progress nor starts another frame afterwards.
- R9: Whenever busy is 0, `tx_line` is 1, including between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = character register, 1 = mode register |
| wr_data | input | 16 | Write data |
| rd_mode | output | 16 | Mode readback: [2:0] mode bits, [3] busy, [15:4] zero |
| tx_line | output | 1 | Serial output line |

## Verification
The bench checks that the start bit falls exactly one cycle after the write and that the data bits come LSB first. A design that sent MSB first or used an extra bit period would fail the per-bit samples. In the all-zero test mode it writes a nonzero character and expects zero data bits. A design that leaked the register value would send ones. It writes the character register in the middle of a frame to catch a design that reloads the shifter or queues a second frame. It sets the mark override during a string of zero bits to expose a design that keeps shifting underneath, leaves busy set, or starts frames while forced. It also writes ones to the read-only and unused mode bits.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    localparam int MODE_ZERO_BIT = 0;
    localparam int MODE_DATA_BIT = 1;
    localparam int MODE_MARK_BIT = 2;
    localparam int MODE_BUSY_BIT = 3;
    localparam int MODE_FIELD_W  = 3;
endpackage

// File: rtl/mtx_regs.sv
module mtx_regs
    import mtx_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              fsm_busy,
    output logic              launch,
    output logic [CHAR_W-1:0] launch_char,
    output logic              abort,
    output logic              force_mark,
    output logic [REG_W-1:0]  rd_mode
);
    logic [CHAR_W-1:0]       char_q;
    logic [MODE_FIELD_W-1:0] mode_q;
    logic                    pend_q;
    logic                    pend_zero_q;
    logic                    char_wr;
    logic                    mode_wr;
    logic                    can_frame;
    logic                    unused_wr_hi;

    assign char_wr   = wr_en && !wr_sel;
    assign mode_wr   = wr_en && wr_sel;
    assign can_frame = !mode_q[MODE_MARK_BIT]
                       && (mode_q[MODE_DATA_BIT] || mode_q[MODE_ZERO_BIT]);
    assign abort     = mode_wr && wr_data[MODE_MARK_BIT];
    assign unused_wr_hi = ^wr_data[REG_W-1:CHAR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
            mode_q <= '0;
        end else begin
            if (char_wr) begin
                char_q <= wr_data[CHAR_W-1:0];
            end
            if (mode_wr) begin
                mode_q <= wr_data[MODE_FIELD_W-1:0];
            end
        end
    end

    // launch stage: one-cycle hold between the write and the frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_zero_q <= 1'b0;
        end else if (abort) begin
            pend_q      <= 1'b0;
        end else if (pend_q) begin
            pend_q      <= 1'b0;
        end else if (char_wr && can_frame && !fsm_busy) begin
            pend_q      <= 1'b1;
            pend_zero_q <= !mode_q[MODE_DATA_BIT];
        end
    end

    always_comb begin
        launch      = pend_q;
        launch_char = pend_zero_q ? '0 : char_q;
        force_mark  = mode_q[MODE_MARK_BIT];
        rd_mode     = '0;
        rd_mode[MODE_FIELD_W-1:0] = mode_q;
        rd_mode[MODE_BUSY_BIT]    = pend_q || fsm_busy;
    end
endmodule

// File: rtl/mtx_bit_timer.sv
module mtx_bit_timer #(
    parameter int CLK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == CNT_LAST);
endmodule

// File: rtl/mtx_frame_fsm.sv
module mtx_frame_fsm
    import mtx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [CHAR_W-1:0] launch_char,
    input  logic              abort,
    input  logic              tick,
    output logic              busy,
    output logic              timer_run,
    output logic              frame_tx
);
    localparam int IDX_W = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAR_W - 1);

    tx_state_e         state_q, state_d;
    logic [CHAR_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last_bit;

    assign last_bit = (idx_q == IDX_LAST);

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (launch) state_d = ST_START;
                ST_START: if (tick)   state_d = ST_DATA;
                ST_DATA:  if (tick && last_bit) state_d = ST_STOP;
                ST_STOP:  if (tick)   state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
        end else if (state_q == ST_IDLE && launch && !abort) begin
            shift_q <= launch_char;
            idx_q   <= '0;
        end else if (state_q == ST_DATA && tick) begin
            shift_q <= shift_q >> 1;
            if (!last_bit) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        timer_run = busy;
        unique case (state_q)
            ST_IDLE:  frame_tx = 1'b1;
            ST_START: frame_tx = 1'b0;
            ST_DATA:  frame_tx = shift_q[0];
            ST_STOP:  frame_tx = 1'b1;
            default:  frame_tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/modal_serial_tx.sv
module modal_serial_tx
    import mtx_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int CHAR_W  = 8,
    parameter int CLK_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_mode,
    output logic             tx_line
);
    logic              launch;
    logic [CHAR_W-1:0] launch_char;
    logic              abort;
    logic              force_mark;
    logic              fsm_busy;
    logic              timer_run;
    logic              tick;
    logic              frame_tx;

    mtx_regs #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .fsm_busy    (fsm_busy),
        .launch      (launch),
        .launch_char (launch_char),
        .abort       (abort),
        .force_mark  (force_mark),
        .rd_mode     (rd_mode)
    );

    mtx_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .clear (launch || abort),
        .tick  (tick)
    );

    mtx_frame_fsm #(.CHAR_W(CHAR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_char (launch_char),
        .abort       (abort),
        .tick        (tick),
        .busy        (fsm_busy),
        .timer_run   (timer_run),
        .frame_tx    (frame_tx)
    );

    assign tx_line = force_mark || frame_tx;
endmodule

// File: rtl/modal_serial_tx_checker.sv
module modal_serial_tx_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_mode,
    input logic             tx_line
);
    p_mark_holds_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode[2] |-> tx_line);

    p_idle_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mode[3] |-> tx_line);

    p_off_no_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && rd_mode[2:0] == 3'b000 && !rd_mode[3]) |=> !rd_mode[3]);

    p_launch_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && rd_mode[1:0] != 2'b00 && !rd_mode[2] && !rd_mode[3])
        |=> rd_mode[3]);

    p_start_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_mode[3]) && !(wr_en && wr_sel && wr_data[2])) |=> !tx_line);

    p_upper_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode[REG_W-1:4] == '0);
endmodule

bind modal_serial_tx modal_serial_tx_checker #(.REG_W(REG_W)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_mode (rd_mode),
    .tx_line (tx_line)
);

// File: tb/modal_serial_tx_tb.sv
module modal_serial_tx_tb;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_mode;
    logic        tx_line;

    int checks = 0;
    int errors = 0;
    int frames_done = 0;
    bit mon_off = 1'b0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    modal_serial_tx #(.CLK_DIV(D)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_mode (rd_mode),
        .tx_line (tx_line)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: push the expected character, write it, check the launch timing
    task automatic send(input logic [7:0] val, input logic [7:0] exp, input logic [2:0] mode, input string req);
        int target;
        target = frames_done + 1;
        exp_q.push_back(exp);
        wr(1'b0, {8'h00, val});
        chk({req, " busy after write (R7)"}, rd_mode, {12'h000, 1'b1, mode});
        chk({req, " line before start"}, {15'h0, tx_line}, 16'h1);
        wait (frames_done == target);
        idle(2);
    endtask

    // monitor: pop an expected character at each start bit, sample mid-bit
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !mon_off && tx_line == 1'b0) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2/R8: unexpected frame start, actual 0 expected 1");
                    wait (tx_line == 1'b1);
                end else begin
                    logic [7:0] c;
                    c = exp_q.pop_front();
                    repeat (D / 2) @(negedge clk);
                    chk("R3 start bit", {15'h0, tx_line}, 16'h0);
                    for (int k = 0; k < 8; k++) begin
                        repeat (D) @(negedge clk);
                        chk($sformatf("R3 data bit %0d", k), {15'h0, tx_line}, {15'h0, c[k]});
                    end
                    repeat (D) @(negedge clk);
                    chk("R3 stop bit", {15'h0, tx_line}, 16'h1);
                    repeat (D - D / 2) @(negedge clk);
                    chk("R9 busy clear after stop", {15'h0, rd_mode[3]}, 16'h0);
                    chk("R9 line idle after stop", {15'h0, tx_line}, 16'h1);
                    frames_done++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit stayed;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 mode after reset", rd_mode, 16'h0000);
        chk("R1 line after reset", {15'h0, tx_line}, 16'h1);

        // R2: transmitter off
        wr(1'b0, 16'h00A5);
        idle(12 * D);
        chk("R2 busy while off", {15'h0, rd_mode[3]}, 16'h0);
        chk("R2 line while off", {15'h0, tx_line}, 16'h1);

        // R3: data mode
        wr(1'b1, 16'h0002);
        chk("R7 mode readback", rd_mode, 16'h0002);
        send(8'hA5, 8'hA5, 3'b010, "R3");
        send(8'h3C, 8'h3C, 3'b010, "R3");
        send(8'h01, 8'h01, 3'b010, "R3");
        send(8'h80, 8'h80, 3'b010, "R3");

        // R4: all-zero test mode
        wr(1'b1, 16'h0001);
        send(8'hFF, 8'h00, 3'b001, "R4");

        // R5: data bit wins over zero bit
        wr(1'b1, 16'h0003);
        send(8'h5A, 8'h5A, 3'b011, "R5");

        // R8: write during a frame
        wr(1'b1, 16'h0002);
        begin
            int target;
            target = frames_done + 1;
            exp_q.push_back(8'h96);
            wr(1'b0, 16'h0096);
            idle(4 * D);
            wr(1'b0, 16'h00FF);
            wait (frames_done == target);
            idle(12 * D);
            chk("R8 no second frame", {15'h0, rd_mode[3]}, 16'h0);
        end

        // R7: read-only and unused bits
        wr(1'b1, 16'hFFF3);
        chk("R7 masked write", rd_mode, 16'h0003);

        // R6: mark override aborts
        wr(1'b1, 16'h0002);
        mon_off = 1'b1;
        wr(1'b0, 16'h0000);
        idle(3 * D);
        chk("R6 frame running before override", {15'h0, tx_line}, 16'h0);
        wr(1'b1, 16'h0006);
        chk("R6 busy cleared by override", rd_mode, 16'h0006);
        chk("R6 line forced", {15'h0, tx_line}, 16'h1);
        wr(1'b0, 16'h0000);
        stayed = 1'b1;
        for (int i = 0; i < 12 * D; i++) begin
            @(negedge clk);
            if (tx_line !== 1'b1 || rd_mode[3] !== 1'b0) stayed = 1'b0;
        end
        chk("R6 no frame while forced", {15'h0, stayed}, 16'h1);
        mon_off = 1'b0;
        wr(1'b1, 16'h0002);
        send(8'h33, 8'h33, 3'b010, "R6 recovery");

        finish_run();
    end
endmodule